// File: doc/BRIEF.md
# Partitioned Inter-Processor Interrupt Unit

This unit lets any processor core post software interrupts to any set of cores. Each core owns a 16-bit cause register. Every core has its own write port into the unit, and any port can post a cause bit to many cores in one write. A core acknowledges work by clearing bits in its own cause register with a write-one-to-clear access. All cause registers and a shared partition register can be read back through a single read port.

The 16 cause bits do not each have their own wire. They fall into four fixed groups: bit 0 alone, bits 1 to 3, bits 4 to 7 and bits 8 to 15. A group is active while any of its bits is set. The partition register holds one 2-bit line selector per group. Each core has three interrupt lines, and each line is the OR of every active group that selects it. A selector value of 3 takes the group off all lines. This gives software a small, programmable priority fold of up to sixteen message kinds onto three interrupt levels.

Address map: posting addresses are 0x00 to 0x0F. Address 0x10+c is the clear and read address of core c's cause register, and address 0x30 is the partition register. Interrupt outputs come straight from the stored state, so a write shows on the lines in the cycle after the clock edge that captured it.

Top module: `ipi_part_unit`

## Requirements
- R1: A write to posting address b (0x00 to 0x0F) sets cause bit b in every core c whose data bit c is 1 and leaves that core's other cause bits unchanged.
- R2: Data bits at positions equal to or above the configured core count have no effect on any cause register.
- R3: A write of D to core c's clear address (0x10+c) clears the bits of core c's cause register where D[15:0] is 1. No other core's cause register changes.
- R4: When one cause bit of one core is posted and cleared in the same cycle, the bit ends up set.
- R5: Group 0 is cause bit 0, group 1 is bits 1 to 3, group 2 is bits 4 to 7 and group 3 is bits 8 to 15. A group is active when at least one of its bits is 1.
- R6: The partition register (address 0x30, bits [7:0]) holds the line selector for group k in bits [2k+1:2k]. An active group drives the interrupt line whose index is its selector. Line j of core c is output bit 3c+j.
- R7: An active group whose selector is 3 drives no line.
- R8: A line selected by several groups stays asserted while any one of them is active.
- R9: After reset, every cause register and the partition register read 0 and every interrupt line is low.
- R10: A read of 0x10+c returns core c's cause in bits [15:0]. A read of 0x30 returns the partition register in bits [7:0]. A read of any posting address returns 0. All other read data bits are 0.
- R11: Posts from several ports in the same cycle all take effect.
- R12: When several ports write the partition register in the same cycle, the write from the lowest-numbered port is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | NUM_PORTS | Write strobe, one per port |
| wr_addr | input | NUM_PORTS*ADDR_W | Write address; port p uses bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_PORTS*DATA_W | Write data; port p uses bits [p*DATA_W +: DATA_W] |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data for rd_addr |
| irq_o | output | NUM_CORES*3 | Interrupt lines; line j of core c is bit 3c+j |

## Verification
The bench targets the same-cycle collisions. A post and a clear that hit the same bit must leave the bit set; a design that applies the clear last would lose an interrupt. Simultaneous posts from four ports must all land; a design that served one port would drop the others. Conflicting partition writes must keep the lowest port's value; a design with the wrong priority would return the other value on read-back. The bench walks every cause bit across the group edges (bits 1/3, 4/7 and 8/15), so a group decoded off by one bit raises the wrong line. It drives every group through selectors 0 to 3, where a design that treats 3 as a valid line index would raise a line that should stay low. A shared line is checked with one of its two sources cleared, which a design that replaces the line value instead of ORing it would get wrong. Data bits above the core count are also driven, and a design that wraps those bits onto real cores would corrupt their cause registers.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  localparam int CAUSE_W = 16;
  localparam int IDX_W   = $clog2(CAUSE_W);
  localparam int GROUPS  = 4;
  localparam int LINES   = 3;
  localparam int SEL_W   = 2;
  localparam int PART_W  = GROUPS * SEL_W;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [PART_W-1:0]  part_t;
  typedef logic [GROUPS-1:0]  grp_t;
  typedef logic [LINES-1:0]   line_t;

  // Fold the cause bits into four activity flags with fixed boundaries.
  function automatic grp_t fold_groups(cause_t c);
    grp_t g;
    g[0] = c[0];
    g[1] = |c[3:1];
    g[2] = |c[7:4];
    g[3] = |c[15:8];
    return g;
  endfunction

  // Steer each active group onto the line its selector names.
  function automatic line_t steer_groups(grp_t g, part_t p);
    line_t l;
    logic [SEL_W-1:0] sel;
    l = '0;
    for (int k = 0; k < GROUPS; k++) begin
      sel = p[k*SEL_W +: SEL_W];
      for (int j = 0; j < LINES; j++) begin
        if (g[k] && (sel == SEL_W'(j))) l[j] = 1'b1;
      end
    end
    return l;
  endfunction
endpackage

// File: rtl/ipi_wr_decode.sv
`timescale 1ns/1ps
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SET_BASE  = 0,
  parameter int CLR_BASE  = 16,
  parameter int PART_ADDR = 48
) (
  input  logic [NUM_PORTS-1:0]            wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0]     wr_addr,
  input  logic [NUM_PORTS*DATA_W-1:0]     wr_data,
  output logic [NUM_CORES-1:0][CAUSE_W-1:0] set_mask,
  output logic [NUM_CORES-1:0][CAUSE_W-1:0] clr_mask,
  output logic                            part_we,
  output part_t                           part_wdata
);
  localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] PART_A = ADDR_W'(PART_ADDR);

  logic [ADDR_W-1:0] a_w [NUM_PORTS];
  logic [DATA_W-1:0] d_w [NUM_PORTS];
  logic [NUM_PORTS-1:0] set_hit;
  logic [NUM_PORTS-1:0] part_hit;
  logic unused_data;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign a_w[p]      = wr_addr[p*ADDR_W +: ADDR_W];
    assign d_w[p]      = wr_data[p*DATA_W +: DATA_W];
    assign set_hit[p]  = wr_en[p] && (a_w[p][ADDR_W-1:IDX_W] == SET_A[ADDR_W-1:IDX_W]);
    assign part_hit[p] = wr_en[p] && (a_w[p] == PART_A);
  end

  assign unused_data = ^wr_data;

  // Posting: data bit c selects core c; bits past NUM_CORES are never looked at.
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (set_hit[p] && d_w[p][c])
          set_mask[c][a_w[p][IDX_W-1:0]] = 1'b1;
        if (wr_en[p] && (a_w[p] == CLR_A + ADDR_W'(c)))
          clr_mask[c] = clr_mask[c] | d_w[p][CAUSE_W-1:0];
      end
    end
  end

  // Partition writes: scan from the top so the lowest port is applied last.
  always_comb begin
    part_we    = 1'b0;
    part_wdata = '0;
    for (int p = NUM_PORTS-1; p >= 0; p--) begin
      if (part_hit[p]) begin
        part_we    = 1'b1;
        part_wdata = d_w[p][PART_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ipi_cause_reg.sv
`timescale 1ns/1ps
module ipi_cause_reg
  import ipi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t set_i,
  input  cause_t clr_i,
  output cause_t cause_o
);
  cause_t cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~clr_i) | set_i;
  end

  assign cause_o = cause_q;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i))); // R4
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((cause_q & $past(clr_i & ~set_i)) == '0)); // R3
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(cause_q)); // R1
endmodule

// File: rtl/ipi_part_reg.sv
`timescale 1ns/1ps
module ipi_part_reg
  import ipi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  part_t wdata_i,
  output part_t part_o
);
  part_t part_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    part_q <= '0;
    else if (we_i) part_q <= wdata_i;
  end

  assign part_o = part_q;

  AST_PART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (part_q == $past(wdata_i))); // R6
  AST_PART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(part_q)); // R6
endmodule

// File: rtl/ipi_line_map.sv
`timescale 1ns/1ps
module ipi_line_map
  import ipi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t cause_i,
  input  part_t  part_i,
  output line_t  line_o
);
  grp_t grp_act;
  grp_t grp_parked;
  logic all_parked;

  assign grp_act = fold_groups(cause_i);
  assign line_o  = steer_groups(grp_act, part_i);

  for (genvar k = 0; k < GROUPS; k++) begin : g_park
    assign grp_parked[k] = !grp_act[k] || (part_i[k*SEL_W +: SEL_W] == '1);
  end
  assign all_parked = &grp_parked;

  AST_LINE_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o != '0) |-> (cause_i != '0)); // R5
  AST_PARKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    all_parked |-> (line_o == '0)); // R7
endmodule

// File: rtl/ipi_part_unit.sv
`timescale 1ns/1ps
module ipi_part_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SET_BASE  = 0,
  parameter int CLR_BASE  = 16,
  parameter int PART_ADDR = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0] wr_addr,
  input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_CORES*LINES-1:0]  irq_o
);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] PART_A = ADDR_W'(PART_ADDR);

  logic [NUM_CORES-1:0][CAUSE_W-1:0] set_mask;
  logic [NUM_CORES-1:0][CAUSE_W-1:0] clr_mask;
  cause_t cause_w [NUM_CORES];
  logic   part_we;
  part_t  part_wdata;
  part_t  part_q;

  ipi_wr_decode #(
    .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
    .PART_ADDR(PART_ADDR)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .part_we(part_we), .part_wdata(part_wdata)
  );

  ipi_part_reg u_part (
    .clk(clk), .rst_n(rst_n), .we_i(part_we), .wdata_i(part_wdata),
    .part_o(part_q)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_cause_reg u_cause (
      .clk(clk), .rst_n(rst_n), .set_i(set_mask[c]), .clr_i(clr_mask[c]),
      .cause_o(cause_w[c])
    );
    ipi_line_map u_map (
      .clk(clk), .rst_n(rst_n), .cause_i(cause_w[c]), .part_i(part_q),
      .line_o(irq_o[c*LINES +: LINES])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rd_addr == CLR_A + ADDR_W'(c)) rd_data = DATA_W'(cause_w[c]);
    end
    if (rd_addr == PART_A) rd_data = DATA_W'(part_q);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0)); // R9
endmodule

// File: tb/ipi_part_unit_tb.sv
`timescale 1ns/1ps
module ipi_part_unit_tb;
  localparam int NC = 4, NP = 4, AW = 8, DW = 32;
  localparam logic [AW-1:0] SETA = 8'h00, CLRA = 8'h10, PARTA = 8'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    wr_en = '0;
  logic [NP*AW-1:0] wr_addr = '0;
  logic [NP*DW-1:0] wr_data = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic [DW-1:0]    rd_data;
  logic [NC*3-1:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_cause [NC];
  logic [7:0]  m_part;

  always #2 clk = ~clk;

  ipi_part_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  // Bench view of line steering: walk the bits, not the groups.
  function automatic logic [2:0] exp_lines(logic [15:0] c, logic [7:0] p);
    logic [2:0] l = '0;
    for (int i = 0; i < 16; i++) begin
      int g = (i == 0) ? 0 : (i < 4) ? 1 : (i < 8) ? 2 : 3;
      int s = p[2*g +: 2];
      if (c[i] && s != 3) l[s] = 1'b1;
    end
    return l;
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic put(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = a;
    wr_data[p*DW +: DW] = d;
  endtask

  task automatic commit();
    @(posedge clk);
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic m_set(int b, logic [31:0] d);
    for (int c = 0; c < NC; c++) if (d[c]) m_cause[c][b] = 1'b1;
  endtask

  task automatic check_all(string rq);
    for (int c = 0; c < NC; c++) begin
      rd_addr = CLRA + AW'(c);
      #0.1;
      check({rq, " cause"}, rd_data, {16'h0, m_cause[c]});
      check({rq, " lines"}, {29'h0, irq_o[c*3 +: 3]}, {29'h0, exp_lines(m_cause[c], m_part)});
    end
    rd_addr = PARTA;
    #0.1;
    check({rq, " partition"}, rd_data, {24'h0, m_part});
  endtask

  task automatic clear_all();
    for (int c = 0; c < NC; c++) begin
      put(c, CLRA + AW'(c), 32'hFFFF_FFFF);
      m_cause[c] = '0;
    end
    commit();
  endtask

  task automatic set_part(logic [7:0] v);
    put(0, PARTA, {24'hABCDEF, v});
    commit();
    m_part = v;
  endtask

  task automatic t_reset();
    check_all("R9");
  endtask

  task automatic t_post();
    put(0, SETA + 8'd5, 32'h5);
    commit();
    m_set(5, 32'h5);
    check_all("R1");
  endtask

  task automatic t_high_bits();
    put(1, SETA + 8'd9, 32'hFFFF_FFF0);
    commit();
    check_all("R2");
  endtask

  task automatic t_clear();
    put(0, CLRA + 8'd0, 32'h0020);
    commit();
    m_cause[0] &= ~16'h0020;
    check_all("R3");
  endtask

  task automatic t_set_wins();
    put(2, SETA + 8'd7, 32'h4);
    commit();
    m_set(7, 32'h4);
    put(0, CLRA + 8'd2, 32'h00A0);
    put(1, SETA + 8'd5, 32'h4);
    commit();
    m_cause[2] &= ~16'h00A0;
    m_set(5, 32'h4);
    check_all("R4");
  endtask

  task automatic t_multi_post();
    put(0, SETA + 8'd1, 32'h1);
    put(1, SETA + 8'd2, 32'h2);
    put(2, SETA + 8'd3, 32'h8);
    put(3, SETA + 8'd15, 32'hF);
    commit();
    m_set(1, 32'h1); m_set(2, 32'h2); m_set(3, 32'h8); m_set(15, 32'hF);
    check_all("R11");
  endtask

  task automatic t_groups();
    clear_all();
    set_part(8'hE4);
    for (int i = 0; i < 16; i++) begin
      put(1, SETA + AW'(i), 32'h8);
      commit();
      m_set(i, 32'h8);
      check("R5 group edge", {29'h0, irq_o[9 +: 3]}, {29'h0, exp_lines(m_cause[3], m_part)});
      put(3, CLRA + 8'd3, 32'hFFFF);
      commit();
      m_cause[3] = '0;
    end
  endtask

  task automatic t_route();
    int rep [4] = '{0, 2, 6, 12};
    for (int g = 0; g < 4; g++) begin
      for (int v = 0; v < 4; v++) begin
        set_part(8'(v << (2*g)));
        put(0, SETA + AW'(rep[g]), 32'h2);
        commit();
        m_set(rep[g], 32'h2);
        if (v == 3) check("R7 parked", {29'h0, irq_o[3 +: 3]}, 32'h0);
        else check("R6 route", {29'h0, irq_o[3 +: 3]}, 32'(1 << v));
        put(1, CLRA + 8'd1, 32'hFFFF);
        commit();
        m_cause[1] = '0;
      end
    end
  endtask

  task automatic t_shared();
    set_part(8'h65);
    put(0, SETA + 8'd0, 32'h2);
    put(1, SETA + 8'd15, 32'h2);
    commit();
    m_set(0, 32'h2); m_set(15, 32'h2);
    check("R8 both", {29'h0, irq_o[3 +: 3]}, 32'h2);
    put(1, CLRA + 8'd1, 32'h0001);
    commit();
    m_cause[1][0] = 1'b0;
    check("R8 one left", {29'h0, irq_o[3 +: 3]}, 32'h2);
    put(1, CLRA + 8'd1, 32'h8000);
    commit();
    m_cause[1] = '0;
    check("R8 none", {29'h0, irq_o[3 +: 3]}, 32'h0);
  endtask

  task automatic t_part_conflict();
    put(2, PARTA, 32'h1B);
    put(1, PARTA, 32'h24);
    commit();
    m_part = 8'h24;
    check_all("R12");
  endtask

  task automatic t_readback();
    put(0, SETA + 8'd3, 32'hF);
    commit();
    m_set(3, 32'hF);
    rd_addr = SETA + 8'd3;
    #0.1;
    check("R10 post addr reads zero", rd_data, 32'h0);
    check_all("R10");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) m_cause[c] = '0;
    m_part = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post();
    t_high_bits();
    t_clear();
    t_set_wins();
    t_multi_post();
    t_groups();
    t_route();
    t_shared();
    t_part_conflict();
    t_readback();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule